// File: doc/BRIEF.md
# General-Purpose I/O Port with a Single Per-Pin Data Flop

This block is a parameterised general-purpose I/O port (eight pins by default) driven from a small register bus. It has these per-pin settings:

- direction;
- alternate-function select;
- weak pull-up enable;
- open-drain enable.

Each pin has exactly one data flip-flop, which serves both bus reads and bus writes. While a pin is an input, that flop reloads the synchronised pad level on every clock. A value written to an input pin is therefore lost at the next capture. When the pin is switched to output, it drives whatever level it last captured.

Each pad is modelled as three signals: an output value, an output enable and a pull-up request. The pad level returns through a multi-stage synchroniser. The alternate-function path is three external signals: an output value and an output enable that can take over the pad, and the synchronised input. Bus writes carry a per-pin mask, so software can touch any subset of pins without a read-modify-write.

Register addresses, all accessed with the pin mask on writes:

- 0: data.
- 1: mode command. A write takes the mode from write-data bits [1:0]; a read returns the direction bits.
- 2: pull-up enables.
- 3: open-drain enables.
- 4: alternate-function select (read only).

Any other address reads zero.

Top module: `gpio_shared_port`

## Requirements
- R1: While reset is asserted, every configuration register reads zero, the data register reads zero and every pad output enable is low. After release, the data flops capture the synchronised pads from the first clock.
- R2: For a pin whose direction bit is 0 (input), a pad change becomes visible in the data register at address 0 on the third rising edge after it: two synchroniser stages, then the capture.
- R3: For a pin whose direction bit is 1 (output), with alternate function and open-drain off, the pad output enable is high and the pad output value equals the pin's data bit.
- R4: A data write to an input pin has no lasting effect: the data register still reads the pad level afterwards.
- R5: When a pin turns from input to output, it drives the level it last captured, not a value written while it was an input.
- R6: A write to address 0 changes only the pins whose mask bit is 1; unmasked bits keep their value.
- R7: A write to address 1 sets the direction bit from write-data bit 0 and the alternate-function bit from bit 1, for masked pins only. It leaves the pull-up and open-drain registers unchanged. Reading address 1 returns the direction bits; reading address 4 returns the alternate-function bits.
- R8: Address 2 holds the pull-up enables and drives pad_pu. An undriven input pad with its pull-up on reads 1.
- R9: With the open-drain bit (address 3) set on an output pin, data 0 drives the pad low with the enable high, and data 1 releases the pad (enable low).
- R10: With the alternate-function bit set, the pad output value and enable come from alt_out and alt_oe, and the data flop keeps its value. alt_in carries the synchronised pad level.
- R11: Reading address 0 returns the flop contents: the captured level for input pins and the last written value for output pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NPINS | Write data (mode command uses bits [1:0]) |
| bus_mask | input | NPINS | Per-pin write mask |
| bus_rdata | output | NPINS | Read data for bus_addr (combinational) |
| pad_in | input | NPINS | Pad levels |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| pad_pu | output | NPINS | Weak pull-up requests to the pads |
| alt_out | input | NPINS | Alternate-function output values |
| alt_oe | input | NPINS | Alternate-function output enables |
| alt_in | output | NPINS | Synchronised pad levels for the alternate function |

## Verification
The bench builds the port with its defaults: eight pins and a two-stage synchroniser. With eight pins, one write can cover mixed groups of inputs, outputs, open-drain and alternate-function pins, and masks can be sparse. With two stages, the capture latency is a fixed three edges, which the bench checks on the edge before and on the edge of the change. A pad model in the bench resolves the pull-ups, an external low driver and the port's own drive. This makes the preload-then-turn-around scenario observable directly on pad_out.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int unsigned REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      GP_DATA = 3'd0,
      GP_MODE = 3'd1,
      GP_PULL = 3'd2,
      GP_ODRN = 3'd3,
      GP_ALT  = 3'd4
   } gp_reg_e;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_port_cfg.sv
module gpio_port_cfg #(
   parameter int unsigned NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_mode,
   input  logic             we_pull,
   input  logic             we_odrn,
   input  logic [1:0]       mode,
   input  logic [NPINS-1:0] wdata,
   input  logic [NPINS-1:0] mask,
   output logic [NPINS-1:0] dir_q,
   output logic [NPINS-1:0] alt_q,
   output logic [NPINS-1:0] pull_q,
   output logic [NPINS-1:0] odrn_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         alt_q  <= '0;
         pull_q <= '0;
         odrn_q <= '0;
      end else begin
         if (we_mode) begin
            dir_q <= (dir_q & ~mask) | (mask & {NPINS{mode[0]}});
            alt_q <= (alt_q & ~mask) | (mask & {NPINS{mode[1]}});
         end
         if (we_pull) pull_q <= (pull_q & ~mask) | (wdata & mask);
         if (we_odrn) odrn_q <= (odrn_q & ~mask) | (wdata & mask);
      end
   end
endmodule

// File: rtl/gpio_port_data.sv
module gpio_port_data #(
   parameter int unsigned NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] dir,
   input  logic [NPINS-1:0] smp,
   input  logic             we,
   input  logic [NPINS-1:0] wdata,
   input  logic [NPINS-1:0] mask,
   output logic [NPINS-1:0] q
);
   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             q[i] <= 1'b0;
         else if (!dir[i])       q[i] <= smp[i];
         else if (we && mask[i]) q[i] <= wdata[i];
      end
   end
endmodule

// File: rtl/gpio_port_padmux.sv
module gpio_port_padmux #(
   parameter int unsigned NPINS = 8
) (
   input  logic [NPINS-1:0] dir,
   input  logic [NPINS-1:0] alt,
   input  logic [NPINS-1:0] odrn,
   input  logic [NPINS-1:0] q,
   input  logic [NPINS-1:0] alt_out,
   input  logic [NPINS-1:0] alt_oe,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe
);
   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic gp_out;
      logic gp_oe;
      assign gp_out     = odrn[i] ? 1'b0 : q[i];
      assign gp_oe      = odrn[i] ? (dir[i] & ~q[i]) : dir[i];
      assign pad_out[i] = alt[i] ? alt_out[i] : gp_out;
      assign pad_oe[i]  = alt[i] ? alt_oe[i]  : gp_oe;
   end
endmodule

// File: rtl/gpio_shared_port.sv
module gpio_shared_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned NPINS       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [NPINS-1:0]  bus_wdata,
   input  logic [NPINS-1:0]  bus_mask,
   output logic [NPINS-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  pad_pu,
   input  logic [NPINS-1:0]  alt_out,
   input  logic [NPINS-1:0]  alt_oe,
   output logic [NPINS-1:0]  alt_in
);
   if (NPINS < 2 || NPINS > 32) begin : g_bad_npins
      $error("gpio_shared_port: NPINS must lie in 2..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("gpio_shared_port: SYNC_STAGES must be at least 2");
   end

   logic [NPINS-1:0] cfg_dir, cfg_alt, cfg_pull, cfg_odrn;
   logic [NPINS-1:0] smp_q, data_q;
   logic             wr_data, wr_mode, wr_pull, wr_odrn;
   logic             unused_wdata_hi;

   assign wr_data = bus_we && (bus_addr == GP_DATA);
   assign wr_mode = bus_we && (bus_addr == GP_MODE);
   assign wr_pull = bus_we && (bus_addr == GP_PULL);
   assign wr_odrn = bus_we && (bus_addr == GP_ODRN);
   assign unused_wdata_hi = ^bus_wdata[NPINS-1:2];

   gpio_port_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(smp_q)
   );

   gpio_port_cfg #(.NPINS(NPINS)) cfg_i (
      .clk(clk), .rst_n(rst_n),
      .we_mode(wr_mode), .we_pull(wr_pull), .we_odrn(wr_odrn),
      .mode(bus_wdata[1:0]), .wdata(bus_wdata), .mask(bus_mask),
      .dir_q(cfg_dir), .alt_q(cfg_alt), .pull_q(cfg_pull), .odrn_q(cfg_odrn)
   );

   gpio_port_data #(.NPINS(NPINS)) data_i (
      .clk(clk), .rst_n(rst_n), .dir(cfg_dir), .smp(smp_q),
      .we(wr_data), .wdata(bus_wdata), .mask(bus_mask), .q(data_q)
   );

   gpio_port_padmux #(.NPINS(NPINS)) mux_i (
      .dir(cfg_dir), .alt(cfg_alt), .odrn(cfg_odrn), .q(data_q),
      .alt_out(alt_out), .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   assign pad_pu = cfg_pull;
   assign alt_in = smp_q;

   always_comb begin
      case (bus_addr)
         GP_DATA: bus_rdata = data_q;
         GP_MODE: bus_rdata = cfg_dir;
         GP_PULL: bus_rdata = cfg_pull;
         GP_ODRN: bus_rdata = cfg_odrn;
         GP_ALT:  bus_rdata = cfg_alt;
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_shared_port_chk.sv
module gpio_shared_port_chk
   import gpio_port_pkg::*;
#(
   parameter int unsigned NPINS = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [REG_AW-1:0] bus_addr,
   input logic [NPINS-1:0]  bus_mask,
   input logic [NPINS-1:0]  cfg_dir,
   input logic [NPINS-1:0]  cfg_alt,
   input logic [NPINS-1:0]  cfg_pull,
   input logic [NPINS-1:0]  cfg_odrn,
   input logic [NPINS-1:0]  smp_q,
   input logic [NPINS-1:0]  data_q,
   input logic [NPINS-1:0]  pad_out,
   input logic [NPINS-1:0]  pad_oe,
   input logic [NPINS-1:0]  alt_oe
);
   // R2 / R4: an input pin always holds the previous synchroniser output
   a_r2_input_capture: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (((~$past(cfg_dir)) & (data_q ^ $past(smp_q))) == '0));

   // R3: plain output pins drive the pad
   a_r3_output_enable: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_dir & ~cfg_alt & ~cfg_odrn & ~pad_oe) == '0));

   // R6: unmasked output bits are untouched by a data write
   a_r6_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == GP_DATA) |=>
      (((data_q ^ $past(data_q)) & ~$past(bus_mask) & $past(cfg_dir)) == '0));

   // R7: a mode command leaves pull-up and open-drain settings alone
   a_r7_mode_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == GP_MODE) |=> ($stable(cfg_pull) && $stable(cfg_odrn)));

   // R9: an open-drain pin never drives high
   a_r9_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_odrn & ~cfg_alt & pad_oe & pad_out) == '0));

   // R10: alternate-function pins take their enable from alt_oe
   a_r10_alt_enable: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_alt & (pad_oe ^ alt_oe)) == '0));

   // R10: the data flop of an alternate-function output pin holds
   a_r10_alt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we) |=> (((data_q ^ $past(data_q)) & $past(cfg_alt) & $past(cfg_dir)) == '0));
endmodule

bind gpio_shared_port gpio_shared_port_chk #(.NPINS(NPINS)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_mask(bus_mask), .cfg_dir(cfg_dir), .cfg_alt(cfg_alt),
   .cfg_pull(cfg_pull), .cfg_odrn(cfg_odrn), .smp_q(smp_q),
   .data_q(data_q), .pad_out(pad_out), .pad_oe(pad_oe), .alt_oe(alt_oe)
);

// File: tb/gpio_shared_port_tb_top.sv
module gpio_shared_port_tb_top;
   import gpio_port_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 8;
   localparam int SETTLE     = 6;

   typedef struct packed {
      logic        we;
      logic [2:0]  addr;
      logic [7:0]  wdata;
      logic [7:0]  mask;
      logic [2:0]  raddr;
      logic [7:0]  exp;
      logic [3:0]  req;
   } vec_t;

   // Pads float low unless pulled up; external drivers only on directed tests.
   localparam vec_t VEC [10] = '{
      '{1'b1, 3'd2, 8'hFF, 8'hFF, 3'd0, 8'hFF, 4'd8},  // R8 pull-ups make floating inputs read 1
      '{1'b1, 3'd0, 8'h00, 8'hFF, 3'd0, 8'hFF, 4'd4},  // R4 write to inputs is overwritten
      '{1'b1, 3'd1, 8'h01, 8'h0F, 3'd1, 8'h0F, 4'd7},  // R7 mode bit0 sets direction of masked pins
      '{1'b0, 3'd0, 8'h00, 8'h00, 3'd0, 8'hFF, 4'd5},  // R5 new outputs drive captured 1
      '{1'b1, 3'd0, 8'h00, 8'h0F, 3'd0, 8'hF0, 4'd11}, // R11 outputs read written value
      '{1'b1, 3'd0, 8'hA5, 8'h03, 3'd0, 8'hF1, 4'd6},  // R6 only masked bits change
      '{1'b1, 3'd3, 8'hFF, 8'h01, 3'd3, 8'h01, 4'd9},  // R9 open-drain register masked write
      '{1'b0, 3'd0, 8'h00, 8'h00, 3'd2, 8'hFF, 4'd7},  // R7 pull-ups untouched by mode writes
      '{1'b1, 3'd1, 8'h00, 8'h0F, 3'd0, 8'hFF, 4'd2},  // R2 back to inputs, capture pulled-up pads
      '{1'b1, 3'd1, 8'h01, 8'h0F, 3'd0, 8'hFF, 4'd5}   // R5 outputs again, drive captured 1 not old 0
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_we = 1'b0;
   logic [2:0]   bus_addr = '0;
   logic [N-1:0] bus_wdata = '0, bus_mask = '0, bus_rdata;
   logic [N-1:0] pad_in, pad_out, pad_oe, pad_pu;
   logic [N-1:0] alt_out = '0, alt_oe = '0, alt_in;
   logic [N-1:0] ext_en = '0, ext_val = '0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // Pad model: a low from either side wins; undriven pads follow the pull-up.
   for (genvar i = 0; i < N; i++) begin : g_pad
      assign pad_in[i] = (pad_oe[i] || ext_en[i]) ?
                         ((pad_oe[i] ? pad_out[i] : 1'b1) & (ext_en[i] ? ext_val[i] : 1'b1)) :
                         pad_pu[i];
   end

   gpio_shared_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_mask(bus_mask), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
      .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in)
   );

   task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [N-1:0] d, input logic [N-1:0] m);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_mask = m;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0; bus_mask = '0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [N-1:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      logic [N-1:0] rd;
      // R1: reset state
      idle(3);
      for (int a = 0; a < 5; a++) begin
         bus_addr = 3'(a);
         #1 check($sformatf("R1 reset reg %0d", a), bus_rdata, '0);
      end
      check("R1 reset pad_oe", pad_oe, '0);
      @(negedge clk) rst_n = 1'b1;
      idle(SETTLE);
      bus_read(3'd0, rd);
      check("R1 capture floating pads", rd, 8'h00);

      // Vector table
      for (int v = 0; v < 10; v++) begin
         if (VEC[v].we) bus_write(VEC[v].addr, VEC[v].wdata, VEC[v].mask);
         idle(SETTLE);
         bus_read(VEC[v].raddr, rd);
         check($sformatf("R%0d vector %0d", VEC[v].req, v), rd, VEC[v].exp);
      end

      // R3: pins 1..3 plain outputs at 1, pin 0 open-drain released
      check("R3 pad_oe", pad_oe, 8'h0E);
      check("R3 pad_out[3:1]", {5'b0, pad_out[3:1]}, 8'h07);

      // R9: open-drain pin 0 written 0 drives low
      bus_write(3'd0, 8'h00, 8'h01);
      #1 check("R9 od drive enable", pad_oe, 8'h0F);
      check("R9 od drive low", {7'b0, pad_out[0]}, 8'h00);

      // R10: pin 1 handed to the alternate function
      alt_out = '0; alt_oe = 8'h02;
      bus_write(3'd1, 8'h03, 8'h02);
      #1 check("R10 alt pad_oe bit1", {7'b0, pad_oe[1]}, 8'h01);
      check("R10 alt pad_out bit1", {7'b0, pad_out[1]}, 8'h00);
      idle(SETTLE);
      check("R10 alt_in bit1", {7'b0, alt_in[1]}, 8'h00);
      bus_read(3'd0, rd);
      check("R10 data flop holds", {7'b0, rd[1]}, 8'h01);
      bus_read(3'd4, rd);
      check("R7 alt register read", rd, 8'h02);
      bus_write(3'd1, 8'h01, 8'h02);
      #1 check("R10 data restored after alt off", {7'b0, pad_out[1]}, 8'h01);

      // R2: exact capture latency on pin 7
      @(negedge clk) begin ext_en = 8'h80; ext_val = 8'h00; bus_addr = 3'd0; end
      @(negedge clk);
      @(negedge clk);
      #1 check("R2 two edges still old", {7'b0, bus_rdata[7]}, 8'h01);
      @(negedge clk);
      #1 check("R2 third edge captured", {7'b0, bus_rdata[7]}, 8'h00);

      // R4 / R5: preload 1 on input pin 7 held low, then turn it around
      bus_write(3'd0, 8'hFF, 8'h80);
      idle(2);
      bus_read(3'd0, rd);
      check("R4 preload lost", {7'b0, rd[7]}, 8'h00);
      bus_write(3'd1, 8'h01, 8'h80);
      #1 check("R5 turnaround enable", {7'b0, pad_oe[7]}, 8'h01);
      check("R5 turnaround drives captured 0", {7'b0, pad_out[7]}, 8'h00);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule